// File: doc/BRIEF.md
# Host Interrupt Line Handshake

This block sits on the device side of a host link and drives one active-low interrupt request line toward the host. Up to sixteen internal event sources feed a latched status register. The host reads that register through a simple read strobe, and each read clears the register. The host serial bus itself is not part of this block. The read strobe, the returned data and a level-sensitive mask bit stand in for it.

The line stays low from reset until the device reports that its initialization is complete. It then parks high. After that, any latched event that is not masked pulls the line low. The host acknowledges by setting the mask, which releases the line at once while the events stay latched. The host then reads and clears the status and clears the mask. If anything is still latched when the mask clears, the line falls again.

Top module: `hirq_top`

## Requirements
- R1: From reset until the first cycle in which `init_done_i` is 1, `irq_no` is 0, whatever the events and the mask are doing.
- R2: After the clock edge that samples `init_done_i` = 1 for the first time, `irq_no` is 1 for at least one cycle, even when events are already latched.
- R3: After initialization, an event latched with the mask clear drives `irq_no` from 1 to 0. An event sampled at edge k sets its status bit at edge k, and the line falls at edge k+1.
- R4: After initialization, if `host_mask_i` = 1 is sampled at an edge, `irq_no` is 1 after that edge. The latched status bits are kept while the mask is set.
- R5: While `stat_rd_i` = 1, `stat_rdata_o` shows all latched status bits. The register is cleared at the same edge, so a second read returns only bits that arrived since. While `stat_rd_i` = 0, `stat_rdata_o` is 0.
- R6: An event that arrives in the same cycle as a read is not part of that read's data. It stays latched and is returned by the next read.
- R7: When the mask clears while status bits are still latched, `irq_no` falls after the first edge that samples the mask clear.
- R8: When a read clears every latched bit while the line is low and unmasked, `irq_no` returns to 1 after the following edge.
- R9: Status bit i records a 1 on `ev_i[i]`. Events on different sources and in different cycles accumulate by OR until they are read.
- R10: Once initialization is complete, later values of `init_done_i` have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | NUM_SRC | Event sources, one per status bit, sampled each cycle |
| init_done_i | input | 1 | Device initialization complete |
| host_mask_i | input | 1 | Host interrupt mask, 1 = masked |
| stat_rd_i | input | 1 | Status read strobe; the read clears the status |
| stat_rdata_o | output | NUM_SRC | Status read data, valid while the strobe is high |
| irq_no | output | 1 | Interrupt request line to the host, active low |

## Verification
The bench latches events before initialization. A design that lets the line fall early, or skips the high park at init, is caught by the line value in the first cycles after `init_done_i`. It reads the status in the same cycle as a new event, and again in the next cycle. A design that drops the new event, or returns it early, shows the wrong word on one of the two reads. It also sets the mask with events pending, then clears it. A design that clears the status on mask, or fails to refire on unmask, leaves the line high when it should fall. Finally it toggles `init_done_i` after initialization, which a non-sticky init flag turns into a spurious low line.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  // line controller states: low before init, parked high, requesting
  typedef enum logic [1:0] {
    LN_OFF  = 2'd0,
    LN_PARK = 2'd1,
    LN_FIRE = 2'd2
  } line_st_e;
endpackage

// File: rtl/hirq_status.sv
module hirq_status #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               rd_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               any_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // set wins over the clear-on-read so a coincident event survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (ev_i[i])  pend_q[i] <= 1'b1;
      else if (rd_i)     pend_q[i] <= 1'b0;
    end
  end

  assign rdata_o = rd_i ? pend_q : '0;
  assign any_o   = |pend_q;
endmodule

// File: rtl/hirq_line_fsm.sv
module hirq_line_fsm
  import hirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic mask_i,
  input  logic any_i,
  output logic irq_no
);
  line_st_e st_q, st_d;
  logic     irq_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LN_OFF:  if (init_done_i)           st_d = LN_PARK;
      LN_PARK: if (any_i && !mask_i)      st_d = LN_FIRE;
      LN_FIRE: if (mask_i || !any_i)      st_d = LN_PARK;
      default:                            st_d = LN_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LN_OFF;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= (st_d == LN_PARK);
    end
  end

  assign irq_no = irq_q;
endmodule

// File: rtl/hirq_top.sv
module hirq_top #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               init_done_i,
  input  logic               host_mask_i,
  input  logic               stat_rd_i,
  output logic [NUM_SRC-1:0] stat_rdata_o,
  output logic               irq_no
);
  logic any_pend;

  hirq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev_i),
    .rd_i    (stat_rd_i),
    .rdata_o (stat_rdata_o),
    .any_o   (any_pend)
  );

  hirq_line_fsm u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done_i),
    .mask_i      (host_mask_i),
    .any_i       (any_pend),
    .irq_no      (irq_no)
  );
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] ev_i,
  input logic               init_done_i,
  input logic               host_mask_i,
  input logic               stat_rd_i,
  input logic [NUM_SRC-1:0] stat_rdata_o,
  input logic               irq_no
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (init_done_i) seen_q <= 1'b1;
  end

  // R1
  low_before_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !irq_no);

  // R2
  park_on_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_i && !seen_q) |=> irq_no);

  // R4
  mask_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && host_mask_i) |=> irq_no);

  // R3
  low_only_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !irq_no) |-> !$past(host_mask_i));

  // R5
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |-> (stat_rdata_o == '0));

  // R6
  coincident_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && $past(stat_rd_i)) |-> (stat_rdata_o == $past(ev_i)));
endmodule

bind hirq_top hirq_chk #(.NUM_SRC(NUM_SRC)) u_hirq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ev_i         (ev_i),
  .init_done_i  (init_done_i),
  .host_mask_i  (host_mask_i),
  .stat_rd_i    (stat_rd_i),
  .stat_rdata_o (stat_rdata_o),
  .irq_no       (irq_no)
);

// File: tb/hirq_top_test.sv
module hirq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] ev = '0;
  logic            init_done = 1'b0;
  logic            mask = 1'b0;
  logic            rd = 1'b0;
  logic [NSRC-1:0] rdata;
  logic            irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hirq_top #(.NUM_SRC(NSRC)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ev_i         (ev),
    .init_done_i  (init_done),
    .host_mask_i  (mask),
    .stat_rd_i    (rd),
    .stat_rdata_o (rdata),
    .irq_no       (irq_n)
  );

  typedef struct {
    logic            irq;
    logic [NSRC-1:0] rdat;
    string           tag;
  } exp_t;

  exp_t exp_q[$];

  // requirement model: latched status and line state (0 off, 1 parked, 2 requesting)
  logic [NSRC-1:0] m_pend = '0;
  int              m_st   = 0;

  task automatic check(input string tag, input string what, input logic [NSRC-1:0] act,
                       input logic [NSRC-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [NSRC-1:0] e, input logic r, input logic m,
                     input logic i, input string tag);
    exp_t it;
    @(negedge clk);
    ev = e; rd = r; mask = m; init_done = i;
    it.irq  = (m_st == 1);
    it.rdat = r ? m_pend : '0;
    it.tag  = tag;
    exp_q.push_back(it);
    case (m_st)
      0: if (i) m_st = 1;
      1: if (m_pend != '0 && !m) m_st = 2;
      default: if (m || m_pend == '0) m_st = 1;
    endcase
    m_pend = (r ? '0 : m_pend) | e;
  endtask

  // monitor: compares once the driven inputs have settled, before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.tag, "irq_no", {{(NSRC-1){1'b0}}, irq_n}, {{(NSRC-1){1'b0}}, it.irq});
        check(it.tag, "rdata", rdata, it.rdat);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1 reset state
    check("R1", "irq_no in reset", {{(NSRC-1){1'b0}}, irq_n}, '0);
    check("R5", "rdata in reset", rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc('0, 0, 0, 0, "R1");
    cyc('0, 0, 0, 0, "R1");
    cyc(16'h0005, 0, 0, 0, "R1");
    cyc('0, 0, 0, 0, "R1");
    cyc('0, 0, 0, 0, "R1");
    cyc('0, 0, 0, 1, "R2");
    cyc('0, 0, 0, 0, "R2");
    cyc('0, 0, 0, 0, "R3");
    cyc('0, 1, 0, 0, "R5");
    cyc('0, 0, 0, 0, "R8");
    cyc('0, 0, 0, 0, "R8");
    cyc('0, 1, 0, 0, "R5");
    cyc(16'h0010, 0, 0, 0, "R9");
    cyc(16'h0001, 0, 0, 0, "R9");
    cyc('0, 0, 0, 0, "R9");
    cyc('0, 1, 0, 0, "R9");
    cyc('0, 0, 0, 0, "R8");
    cyc('0, 0, 0, 0, "R8");
    cyc(16'h8000, 0, 0, 0, "R3");
    cyc('0, 0, 0, 0, "R3");
    cyc('0, 0, 0, 0, "R3");
    cyc('0, 0, 1, 0, "R4");
    cyc('0, 0, 1, 0, "R4");
    cyc(16'h0100, 1, 1, 0, "R6");
    cyc('0, 1, 1, 0, "R6");
    cyc(16'h0002, 0, 1, 0, "R4");
    cyc('0, 0, 1, 0, "R4");
    cyc('0, 0, 0, 0, "R7");
    cyc('0, 0, 0, 0, "R7");
    cyc('0, 0, 0, 1, "R10");
    cyc('0, 0, 0, 0, "R10");
    cyc('0, 0, 0, 1, "R10");
    cyc('0, 1, 0, 1, "R5");
    cyc('0, 0, 0, 1, "R10");
    cyc('0, 0, 0, 0, "R10");
    cyc('0, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule